// File: doc/BRIEF.md
# Write-Protected Asynchronous SRAM Port

This block places a byte-wide asynchronous static RAM bus in front of an on-chip storage array. It runs on a system clock that is much faster than the bus strobes. Active-low chip-enable, write-enable and output-enable arrive from an external master, which also supplies an address and data. All of these pass through a two-flop synchronizer. The block then works out read and write cycles from the synchronized strobes. It drives read data back on a data-out bus with a separate drive-enable, which stands in for the tri-state pins.

A write covers the interval in which chip-enable and write-enable are both low. The write is stored when that interval closes, using the address and data last seen inside it. Write-enable takes priority over output-enable for driving the bus. A protect input, active high, stops everything: reads, writes and bus drive. If protection arrives while a write is in progress, that write is discarded.

The address width sets the depth. The default is 11 bits (2K x 8) to keep elaboration light. Set ADDR_W to 15 for the full 32K x 8 organisation.

Top module: `nvs_sram_port`

## Requirements
- R1: With `we_n` high, `ce_n` low, `oe_n` low and `wp` low, `dout_en` is 1 and `dout` holds the stored byte at `addr`. The output reflects inputs held stable for three rising clock edges: two synchronizer stages plus one output register.
- R2: A write begins when `ce_n` and `we_n` are both low. It is stored when the earlier of the two returns high. The stored address and data are the values sampled in the last clock of the overlap, so data changed mid-write is stored with its final value.
- R3: While `we_n` is low, `dout_en` is 0 even when `ce_n` and `oe_n` are both low. This holds for the whole of a write cycle.
- R4: A write whose overlap ends because `ce_n` rises, with `we_n` still low, is stored in the same way as one ended by `we_n`.
- R5: While `wp` is 1, `dout_en` is 0 and a complete strobe sequence stores nothing.
- R6: If `wp` rises during a write, the write stores nothing. No write restarts if `wp` falls again before the overlap ends; a new write needs `ce_n` or `we_n` to go high and then low again.
- R7: During reset (`rst_n` low), `dout_en` is 0 and `dout` is 0.
- R8: `dout` is 0 in every cycle in which `dout_en` is 0.
- R9: A write changes only the addressed byte. Other locations keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wp | input | 1 | Write/access protect, active high |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus (0 when not driven) |
| dout_en | output | 1 | Bus drive enable (1 = drive `dout`) |

## Verification
The cycle decoder is exercised with four kinds of sequence: plain reads, writes closed by write-enable, writes closed by chip-enable, and writes with output-enable held low throughout. Comparing the two kinds of closing edge shows whether the trailing edge is found from either strobe. The output-enable-low writes show whether write-enable really overrides the output drivers. A write whose data changes mid-cycle separates capture at the leading edge from capture at the trailing edge. A separate set of sequences raises protect before a cycle, and another raises it inside one and drops it again while the strobes stay low. Together these separate a blocked access, a write that is discarded, and a write that wrongly resumes.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   // Control strobes as seen at the pins (active-low enables, active-high protect)
   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic wp;
   } strobe_t;

   localparam int STROBE_W = $bits(strobe_t);

   // Write cycle tracking
   typedef enum logic [1:0] {
      WS_IDLE    = 2'd0,
      WS_WRITE   = 2'd1,
      WS_BLOCKED = 2'd2
   } wr_state_e;

endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nvs_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("nvs_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/nvs_wr_ctrl.sv
module nvs_wr_ctrl
   import nvs_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strobe_t           strb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              commit,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [DATA_W-1:0] cm_data,
   output logic              rd_req
);

   wr_state_e state_q, state_d;
   logic      overlap;

   assign overlap = !strb.ce_n && !strb.we_n;
   assign rd_req  = !strb.ce_n && !strb.oe_n && strb.we_n && !strb.wp;

   always_comb begin
      state_d = state_q;
      commit  = 1'b0;
      unique case (state_q)
         WS_IDLE: begin
            if (overlap && !strb.wp) state_d = WS_WRITE;
         end
         WS_WRITE: begin
            if (strb.wp) begin
               state_d = WS_BLOCKED;
            end else if (!overlap) begin
               commit  = 1'b1;
               state_d = WS_IDLE;
            end
         end
         WS_BLOCKED: begin
            if (!overlap) state_d = WS_IDLE;
         end
         default: state_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         cm_addr <= '0;
         cm_data <= '0;
      end else begin
         state_q <= state_d;
         if (overlap && !strb.wp) begin
            cm_addr <= addr;
            cm_data <= din;
         end
      end
   end

   AST_COMMIT_AFTER_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(overlap)); // R2

endmodule

// File: rtl/nvs_store.sv
module nvs_store #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter bit WR_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] wa,
   input  logic [DATA_W-1:0] wd,
   input  logic              rd,
   input  logic [ADDR_W-1:0] ra,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              hit;

   generate
      if (WR_BYPASS) begin : g_bypass
         assign hit = wr && (wa == ra);
      end else begin : g_no_bypass
         assign hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr) mem[wa] <= wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd;
         if (!rd)      rdata <= '0;
         else if (hit) rdata <= wd;
         else          rdata <= mem[ra];
      end
   end

endmodule

// File: rtl/nvs_sram_port.sv
module nvs_sram_port
   import nvs_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit WR_BYPASS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              wp,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   localparam int BUS_W = STROBE_W + ADDR_W + DATA_W;
   // Strobes idle and protect asserted while the synchronizer fills
   localparam logic [BUS_W-1:0] BUS_RST = {4'b1111, {(ADDR_W + DATA_W){1'b0}}};

   generate
      if (ADDR_W < 1 || ADDR_W > 15) begin : g_bad_addr
         $error("nvs_sram_port: ADDR_W must be 1..15");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("nvs_sram_port: DATA_W must be positive");
      end
   endgenerate

   strobe_t           s_strb;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_din;
   logic              commit, rd_req;
   logic [ADDR_W-1:0] cm_addr;
   logic [DATA_W-1:0] cm_data;

   nvs_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ce_n, we_n, oe_n, wp, addr, din}),
      .q     ({s_strb, s_addr, s_din})
   );

   nvs_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .strb    (s_strb),
      .addr    (s_addr),
      .din     (s_din),
      .commit  (commit),
      .cm_addr (cm_addr),
      .cm_data (cm_data),
      .rd_req  (rd_req)
   );

   nvs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_BYPASS(WR_BYPASS)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (commit),
      .wa     (cm_addr),
      .wd     (cm_data),
      .rd     (rd_req),
      .ra     (s_addr),
      .rdata  (dout),
      .rvalid (dout_en)
   );

   AST_WE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !s_strb.we_n |=> !dout_en); // R3
   AST_PROTECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      s_strb.wp |=> (!dout_en && !commit)); // R5
   AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == '0)); // R8
   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_strb.ce_n && !s_strb.oe_n && s_strb.we_n && !s_strb.wp) |=> dout_en); // R1

endmodule

// File: tb/nvs_sram_port_tb.sv
module nvs_sram_port_tb;

   localparam int AW = 11;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int tests  = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk; // 200 MHz

   nvs_sram_port #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .wp(wp), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
   );

   typedef struct packed {
      logic          ce_n, we_n, oe_n, wp;
      logic [AW-1:0] addr;
      logic [DW-1:0] din;
      logic          exp_en;
      logic [DW-1:0] exp_d;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b1,1'b1,1'b0, 11'd5,  8'h00, 1'b0, 8'h00, 4'd8}, // R8 idle
      '{1'b0,1'b0,1'b1,1'b0, 11'd5,  8'hA5, 1'b0, 8'h00, 4'd3}, // R3 write open
      '{1'b1,1'b1,1'b1,1'b0, 11'd5,  8'hA5, 1'b0, 8'h00, 4'd2}, // R2 close by both
      '{1'b0,1'b1,1'b0,1'b0, 11'd5,  8'h00, 1'b1, 8'hA5, 4'd1}, // R1 read back
      '{1'b0,1'b0,1'b0,1'b0, 11'd7,  8'h3C, 1'b0, 8'h00, 4'd3}, // R3 we beats oe
      '{1'b0,1'b1,1'b0,1'b0, 11'd7,  8'h00, 1'b1, 8'h3C, 4'd2}, // R2 we rise, read
      '{1'b0,1'b1,1'b0,1'b0, 11'd5,  8'h00, 1'b1, 8'hA5, 4'd9}, // R9 other addr
      '{1'b0,1'b1,1'b0,1'b1, 11'd5,  8'h00, 1'b0, 8'h00, 4'd5}, // R5 read blocked
      '{1'b0,1'b0,1'b1,1'b1, 11'd5,  8'hFF, 1'b0, 8'h00, 4'd5}, // R5 write blocked
      '{1'b1,1'b1,1'b1,1'b1, 11'd5,  8'hFF, 1'b0, 8'h00, 4'd5}, // R5 close blocked
      '{1'b0,1'b1,1'b0,1'b0, 11'd5,  8'h00, 1'b1, 8'hA5, 4'd5}  // R5 data kept
   };

   task automatic drive(input logic c, input logic w, input logic o, input logic p,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      ce_n = c; we_n = w; oe_n = o; wp = p; addr = a; din = d;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic e_en, input logic [DW-1:0] e_d);
      tests++;
      if (dout_en !== e_en || dout !== e_d) begin
         fails++;
         $display("FAIL %s: en=%0b dout=%02h expected en=%0b dout=%02h",
                  req, dout_en, dout, e_en, e_d);
      end
   endtask

   initial begin
      // R7: reset state
      settle(3);
      check("R7", 1'b0, 8'h00);
      rst_n = 1'b1;
      settle(5);
      check("R7", 1'b0, 8'h00);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].ce_n, VEC[i].we_n, VEC[i].oe_n, VEC[i].wp, VEC[i].addr, VEC[i].din);
         settle(5);
         check($sformatf("R%0d step %0d", VEC[i].req, i), VEC[i].exp_en, VEC[i].exp_d);
      end

      // R2: data changed mid-write is stored with its final value
      drive(0, 0, 1, 0, 11'd20, 8'h12); settle(3);
      drive(0, 0, 1, 0, 11'd20, 8'h34); settle(5);
      drive(1, 1, 1, 0, 11'd20, 8'h00); settle(5);
      check("R2 idle", 1'b0, 8'h00);
      drive(0, 1, 0, 0, 11'd20, 8'h00); settle(5);
      check("R2 late data", 1'b1, 8'h34);

      // R4: write closed by chip enable while we_n stays low
      drive(1, 1, 1, 0, 11'd21, 8'h00); settle(3);
      drive(0, 0, 1, 0, 11'd21, 8'h5A); settle(5);
      drive(1, 0, 1, 0, 11'd21, 8'h5A); settle(5);
      check("R4 ce close quiet", 1'b0, 8'h00);
      drive(1, 1, 1, 0, 11'd21, 8'h00); settle(3);
      drive(0, 1, 0, 0, 11'd21, 8'h00); settle(5);
      check("R4 ce close stored", 1'b1, 8'h5A);

      // R6: protect mid-write aborts; no resume when protect drops in overlap
      drive(1, 1, 1, 0, 11'd9, 8'h00); settle(3);
      drive(0, 0, 1, 0, 11'd9, 8'h11); settle(5);
      drive(1, 1, 1, 0, 11'd9, 8'h11); settle(5);
      drive(0, 0, 1, 0, 11'd9, 8'h77); settle(5);
      drive(0, 0, 1, 1, 11'd9, 8'h77); settle(5);
      drive(0, 0, 1, 0, 11'd9, 8'h77); settle(5);
      drive(1, 1, 1, 0, 11'd9, 8'h77); settle(5);
      drive(0, 1, 0, 0, 11'd9, 8'h00); settle(5);
      check("R6 abort", 1'b1, 8'h11);

      // R3: no drive at any cycle of a write with oe_n and ce_n low
      drive(1, 1, 1, 0, 11'd30, 8'h00); settle(3);
      drive(0, 0, 0, 0, 11'd30, 8'hC3);
      for (int k = 0; k < 6; k++) begin
         settle(1);
         check("R3 throughout", 1'b0, 8'h00);
      end
      drive(0, 1, 0, 0, 11'd30, 8'h00); settle(5);
      check("R3 then read", 1'b1, 8'hC3);

      // R9: earlier locations untouched by later writes
      drive(0, 1, 0, 0, 11'd7, 8'h00); settle(5);
      check("R9 addr7", 1'b1, 8'h3C);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: en=%0b dout=%02h expected completion", dout_en, dout);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule